// File: doc/BRIEF.md
# CPU Sleep Mode Controller

This block sequences the low-power states of a microcontroller core. It watches a one-cycle strobe from the core saying a sleep instruction has run, together with two mode-select bits. When both bits are clear, it stops the CPU clock enable and leaves the peripheral clock enable running, so on-chip modules keep working while the core's register contents are held. When either bit is set, the strobe is passed on as a standby request for a separate block, and the core keeps running.

The core wakes on an interrupt request only when that request is enabled and not masked by the core. A non-maskable interrupt input always wakes the core. On wake-up the CPU clock enable comes back one cycle before a single-cycle pulse asks the core to start interrupt exception processing.

Two active-low reset pins and an active-low standby pin are synchronized and override everything else. The standby pin takes priority over reset, and reset takes priority over wake-up. Reset is held for a minimum number of cycles and then requests reset exception processing.

Top module: `sleep_ctrl`

## Requirements
- R1: After `rst_ni` is released, both clock enables are 1, `irq_exc_o`, `hw_stby_o` and `sw_stby_req_o` are 0, and `rst_exc_o` pulses for one cycle in the cycle after the RST_MIN_CYC-th rising clock edge.
- R2: A sleep strobe in the running state with both `stby_sel_i` and `lpwr_on_i` at 0 clears `cpu_clk_en_o` after the next edge, and `per_clk_en_o` stays 1 throughout sleep.
- R3: A sleep strobe with either control bit at 1 raises `sw_stby_req_o` in the same cycle, and `cpu_clk_en_o` stays 1.
- R4: In sleep, a line with both its `irq_req_i` and `irq_en_i` bits at 1 while `cpu_mask_i` is 0 sets `cpu_clk_en_o` after the next edge and raises `irq_exc_o` for exactly one cycle, one edge later.
- R5: In sleep, requests that are not enabled, or are enabled while `cpu_mask_i` is 1, leave `cpu_clk_en_o` at 0 and `irq_exc_o` at 0.
- R6: `nmi_i` at 1 during sleep wakes the core as in R4, whatever the values of `cpu_mask_i` and `irq_en_i`.
- R7: Either reset pin driven low reaches the state machine through two flops and forces the reset state on the third edge (`cpu_clk_en_o` 1, core held). While the block is in reset, no `irq_exc_o` is raised, even if `nmi_i` is 1.
- R8: Reset is held for at least RST_MIN_CYC cycles. With the pin driven low before edge 1 and high before edge L+1, `rst_exc_o` is 1 after edge max(RST_MIN_CYC+3, L+2), for exactly one cycle.
- R9: The standby pin driven low sets `hw_stby_o` to 1 and both clock enables to 0 after the third edge, even while a reset pin is low. Released before edge L+1, it leads through reset, so `rst_exc_o` follows after edge L+3+RST_MIN_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_instr_i | input | 1 | Sleep-instruction strobe from the core |
| stby_sel_i | input | 1 | Standby-select control bit |
| lpwr_on_i | input | 1 | Low-power-on control bit |
| irq_req_i | input | N_IRQ | Pending maskable interrupt requests |
| irq_en_i | input | N_IRQ | Per-line interrupt enables |
| cpu_mask_i | input | 1 | Core masks all maskable interrupts |
| nmi_i | input | 1 | Non-maskable interrupt request |
| rst_a_ni | input | 1 | First reset pin, active low, asynchronous |
| rst_b_ni | input | 1 | Second reset pin, active low, asynchronous |
| stby_pin_ni | input | 1 | Hardware-standby pin, active low, asynchronous |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| irq_exc_o | output | 1 | Start interrupt exception processing (pulse) |
| rst_exc_o | output | 1 | Start reset exception processing (pulse) |
| hw_stby_o | output | 1 | Hardware standby active |
| sw_stby_req_o | output | 1 | Sleep strobe redirected to software standby |

## Verification
The bench builds the block with N_IRQ=2 and RST_MIN_CYC=4. With these values, all 64 combinations of request, enable, mask and NMI can be applied from sleep, and each is compared with the qualification formula. The short hold window lets reset-pin low times from 1 to 8 cycles land on both sides of the minimum count. The exact cycle of the reset-exception pulse is computed for each of them. Standby-pin releases are checked the same way, with a reset pin held low alongside in some cases.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_WAKE   = 3'd2,
    ST_EXC    = 3'd3,
    ST_RESET  = 3'd4,
    ST_HWSTBY = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  input  logic             nmi_i,
  output logic             wake_o
);
  logic any_enabled;

  assign any_enabled = |(irq_req_i & irq_en_i);
  // NMI bypasses both enable and mask
  assign wake_o      = nmi_i | (any_enabled & ~cpu_mask_i);
endmodule

// File: rtl/rst_timer.sv
module rst_timer #(
  parameter int RST_MIN_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic done_o
);
  localparam int CW = $clog2(RST_MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(RST_MIN_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!hold_i)     cnt_q <= '0;
    else if (!done_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import sleep_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_instr_i,
  input  logic stby_sel_i,
  input  logic lpwr_on_i,
  input  logic wake_i,
  input  logic rst_low_i,
  input  logic stby_low_i,
  input  logic rst_done_i,
  output logic in_reset_o,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic irq_exc_o,
  output logic rst_exc_o,
  output logic hw_stby_o,
  output logic sw_stby_req_o
);
  pwr_state_e state_q, state_d;
  logic       sw_sel;
  logic       pins_quiet;

  assign sw_sel     = stby_sel_i | lpwr_on_i;
  assign pins_quiet = ~stby_low_i & ~rst_low_i;

  always_comb begin
    state_d = state_q;
    if (stby_low_i)                 state_d = ST_HWSTBY;
    else if (state_q == ST_HWSTBY)  state_d = ST_RESET;
    else if (rst_low_i)             state_d = ST_RESET;
    else begin
      unique case (state_q)
        ST_RUN:   if (sleep_instr_i && !sw_sel) state_d = ST_SLEEP;
        ST_SLEEP: if (wake_i)                   state_d = ST_WAKE;
        ST_WAKE:                                state_d = ST_EXC;
        ST_EXC:                                 state_d = ST_RUN;
        ST_RESET: if (rst_done_i)               state_d = ST_RUN;
        default:                                state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign in_reset_o    = (state_q == ST_RESET);
  assign cpu_clk_en_o  = (state_q != ST_SLEEP) && (state_q != ST_HWSTBY);
  assign per_clk_en_o  = (state_q != ST_HWSTBY);
  assign hw_stby_o     = (state_q == ST_HWSTBY);
  assign irq_exc_o     = (state_q == ST_EXC);
  assign rst_exc_o     = in_reset_o & rst_done_i & pins_quiet;
  assign sw_stby_req_o = (state_q == ST_RUN) & sleep_instr_i & sw_sel & pins_quiet;
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int N_IRQ       = 8,
  parameter int RST_MIN_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_instr_i,
  input  logic             stby_sel_i,
  input  logic             lpwr_on_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  input  logic             nmi_i,
  input  logic             rst_a_ni,
  input  logic             rst_b_ni,
  input  logic             stby_pin_ni,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             irq_exc_o,
  output logic             rst_exc_o,
  output logic             hw_stby_o,
  output logic             sw_stby_req_o
);
  localparam int N_PINS = 3;

  logic [N_PINS-1:0] pin_raw, pin_sync_q;
  logic wake, rst_low, stby_low, in_reset, rst_done;

  assign pin_raw = {stby_pin_ni, rst_b_ni, rst_a_ni};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[g]),
      .q_o   (pin_sync_q[g])
    );
  end

  assign rst_low  = ~pin_sync_q[0] | ~pin_sync_q[1];
  assign stby_low = ~pin_sync_q[2];

  wake_qual #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .cpu_mask_i(cpu_mask_i),
    .nmi_i     (nmi_i),
    .wake_o    (wake)
  );

  rst_timer #(.RST_MIN_CYC(RST_MIN_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(in_reset),
    .done_o(rst_done)
  );

  pwr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_instr_i(sleep_instr_i),
    .stby_sel_i   (stby_sel_i),
    .lpwr_on_i    (lpwr_on_i),
    .wake_i       (wake),
    .rst_low_i    (rst_low),
    .stby_low_i   (stby_low),
    .rst_done_i   (rst_done),
    .in_reset_o   (in_reset),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .irq_exc_o    (irq_exc_o),
    .rst_exc_o    (rst_exc_o),
    .hw_stby_o    (hw_stby_o),
    .sw_stby_req_o(sw_stby_req_o)
  );
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic irq_exc_o,
  input logic rst_exc_o,
  input logic hw_stby_o,
  input logic sw_stby_req_o
);
  // R2
  per_clk_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_stby_o |-> per_clk_en_o);

  // R3
  sw_req_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_stby_req_o |-> cpu_clk_en_o);

  // R4
  clk_before_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_o |-> cpu_clk_en_o && $past(cpu_clk_en_o));

  // R4
  exc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_o |=> !irq_exc_o);

  // R7
  rst_not_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_exc_o && irq_exc_o));

  // R8
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_exc_o |=> !rst_exc_o);

  // R9
  stby_clocks_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_o |-> !cpu_clk_en_o && !per_clk_en_o && !irq_exc_o && !rst_exc_o);
endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .irq_exc_o    (irq_exc_o),
  .rst_exc_o    (rst_exc_o),
  .hw_stby_o    (hw_stby_o),
  .sw_stby_req_o(sw_stby_req_o)
);

// File: tb/tb_sleep_ctrl.sv
module tb_sleep_ctrl;
  localparam int N_IRQ = 2;
  localparam int RMIN  = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sleep_instr_i = 0, stby_sel_i = 0, lpwr_on_i = 0;
  logic [N_IRQ-1:0] irq_req_i = '0, irq_en_i = '0;
  logic cpu_mask_i = 0, nmi_i = 0;
  logic rst_a_ni = 1, rst_b_ni = 1, stby_pin_ni = 1;
  logic cpu_clk_en_o, per_clk_en_o, irq_exc_o, rst_exc_o, hw_stby_o, sw_stby_req_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  sleep_ctrl #(.N_IRQ(N_IRQ), .RST_MIN_CYC(RMIN)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic enter_sleep();
    sleep_instr_i = 1; stby_sel_i = 0; lpwr_on_i = 0;
    tick();
    sleep_instr_i = 0;
  endtask

  task automatic leave_sleep();
    nmi_i = 1; tick(); nmi_i = 0; tick(); tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk("R1", "cpu_clk_en", cpu_clk_en_o, 1);
    chk("R1", "per_clk_en", per_clk_en_o, 1);
    chk("R1", "irq_exc", irq_exc_o, 0);
    chk("R1", "hw_stby", hw_stby_o, 0);
    chk("R1", "sw_stby_req", sw_stby_req_o, 0);
    rst_ni = 1;
    for (int k = 1; k <= RMIN + 1; k++) begin
      tick();
      chk("R1", $sformatf("rst_exc after edge %0d", k), rst_exc_o, (k == RMIN) ? 1 : 0);
    end

    // R2 / R3: all control-bit combinations
    for (int b = 0; b < 4; b++) begin
      sleep_instr_i = 1; stby_sel_i = b[0]; lpwr_on_i = b[1];
      #1;
      chk("R3", $sformatf("sw_stby_req bits=%0d", b), sw_stby_req_o, (b != 0) ? 1 : 0);
      #1;
      tick();
      sleep_instr_i = 0; stby_sel_i = 0; lpwr_on_i = 0;
      chk("R2", $sformatf("cpu_clk_en bits=%0d", b), cpu_clk_en_o, (b == 0) ? 0 : 1);
      chk("R2", $sformatf("per_clk_en bits=%0d", b), per_clk_en_o, 1);
      if (b == 0) leave_sleep();
    end

    // R4 / R5 / R6: full sweep of wake qualification
    for (int v = 0; v < 64; v++) begin
      logic [1:0] rq, en;
      logic mk, nm, exp_wake;
      rq = v[1:0]; en = v[3:2]; mk = v[4]; nm = v[5];
      exp_wake = nm | (~mk & |(rq & en));
      enter_sleep();
      irq_req_i = rq; irq_en_i = en; cpu_mask_i = mk; nmi_i = nm;
      tick();
      irq_req_i = '0; irq_en_i = '0; cpu_mask_i = 0; nmi_i = 0;
      if (exp_wake) begin
        chk(nm ? "R6" : "R4", $sformatf("cpu_clk_en v=%0d", v), cpu_clk_en_o, 1);
        chk(nm ? "R6" : "R4", $sformatf("exc early v=%0d", v), irq_exc_o, 0);
        tick();
        chk(nm ? "R6" : "R4", $sformatf("exc v=%0d", v), irq_exc_o, 1);
        tick();
        chk("R4", $sformatf("exc width v=%0d", v), irq_exc_o, 0);
      end else begin
        tick();
        chk("R5", $sformatf("cpu_clk_en v=%0d", v), cpu_clk_en_o, 0);
        chk("R5", $sformatf("exc v=%0d", v), irq_exc_o, 0);
        leave_sleep();
      end
    end

    // R7 / R8: reset-pin low time sweep from sleep
    for (int L = 1; L <= 8; L++) begin
      int first, exp_n, pulses, excs;
      first = -1; pulses = 0; excs = 0;
      exp_n = (RMIN + 3 > L + 2) ? RMIN + 3 : L + 2;
      enter_sleep();
      if (L % 2) rst_a_ni = 0; else rst_b_ni = 0;
      for (int n = 1; n <= 20; n++) begin
        tick();
        if (n == L) begin rst_a_ni = 1; rst_b_ni = 1; end
        if (n == 3) chk("R7", $sformatf("cpu_clk_en in reset L=%0d", L), cpu_clk_en_o, 1);
        if (n >= 3 && first < 0) nmi_i = 1;
        if (irq_exc_o) excs++;
        if (rst_exc_o) begin pulses++; if (first < 0) first = n; end
        if (first >= 0) nmi_i = 0;
      end
      chk("R7", $sformatf("no irq_exc in reset L=%0d", L), excs, 0);
      chk("R8", $sformatf("rst_exc edge L=%0d", L), first, exp_n);
      chk("R8", $sformatf("rst_exc pulses L=%0d", L), pulses, 1);
    end

    // R9: standby pin, alone and with a reset pin low
    for (int c = 0; c < 4; c++) begin
      int first, L;
      first = -1; L = 4 + c;
      if (c[0]) enter_sleep();
      stby_pin_ni = 0;
      if (c[1]) rst_a_ni = 0;
      for (int n = 1; n <= 25; n++) begin
        tick();
        if (n == L) begin stby_pin_ni = 1; rst_a_ni = 1; end
        if (n == 3) begin
          chk("R9", $sformatf("hw_stby c=%0d", c), hw_stby_o, 1);
          chk("R9", $sformatf("cpu_clk_en c=%0d", c), cpu_clk_en_o, 0);
          chk("R9", $sformatf("per_clk_en c=%0d", c), per_clk_en_o, 0);
        end
        if (rst_exc_o && first < 0) first = n;
      end
      chk("R9", $sformatf("rst_exc after standby c=%0d", c), first, L + 3 + RMIN);
      chk("R9", $sformatf("hw_stby cleared c=%0d", c), hw_stby_o, 0);
    end

    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule